// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block contains the digital dividers of an integer-N frequency synthesizer. A reference divider turns reference-clock ticks into comparison pulses at the phase-detector rate. Its ratio is 6 or 8, selected by one bit, so a 10.368 MHz or a 13.824 MHz reference both give a 1.728 MHz comparison rate. A pulse-swallow feedback divider turns VCO ticks into feedback pulses. It is built from a 32/33 prescaler, a main counter and a swallow counter. Both clocks arrive as single-cycle enable strobes on one fast system clock. Each divider produces a one-cycle pulse at the end of every division cycle.

A lock watcher compares the two pulse trains. A comparison period is good when the second pulse of a pair follows the first within a window of VCO ticks. After enough consecutive good periods the loop is declared locked. A single status pin shows one of the following, chosen by a 3-bit test code: the lock flag, either divider output halved, or the raw reference pulse. The analog phase detector, charge pump and oscillator are outside this block.

Top module: `pll_div_chain`

## Requirements
- R1: The reference divider emits `ref_pulse` for one cycle, one clock after every R-th `ref_en` tick. R is 6 when `ref_sel`=0 and 8 when `ref_sel`=1.
- R2: The main count is 80 plus `main_code` (80..95), and the swallow count is `swal_code` (0..31). The prescaler divides by 33 while swallow periods remain and by 32 after that. `fb_pulse` is therefore high for one cycle, one clock after every N-th `vco_en` tick, where N = 32 × main + swallow.
- R3: Each divider samples its setting on the first tick of a division cycle. A setting changed in the middle of a cycle takes effect only in the next cycle.
- R4: Status codes 3'b000 and 3'b100 put the lock flag on `status` (1 = locked, 0 = unlocked).
- R5: Codes 3'b001 and 3'b101 show the feedback output halved. Codes 3'b010 and 3'b110 show the reference output halved. Each halved signal is 0 after reset and inverts with every pulse of its divider.
- R6: Code 3'b111 puts the raw reference pulse on `status`. Code 3'b011 drives `status` low.
- R7: A period is good when the pulse that was missing arrives no more than LOCK_WIN (8) VCO ticks after the first pulse. Pulses that arrive in the same cycle also count as good. The lock flag rises one clock after the 16th consecutive good period.
- R8: A period is bad when the window expires, or when the same pulse arrives twice with no pulse from the other divider in between. A bad period clears the lock flag and the good-period count one clock later.
- R9: After reset, `ref_pulse`, `fb_pulse`, the halved outputs and the lock flag are all 0.
- R10: `ref_pulse` and `fb_pulse` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference clock tick strobe |
| vco_en | input | 1 | VCO clock tick strobe |
| ref_sel | input | 1 | Reference ratio select (0: 6, 1: 8) |
| main_code | input | 4 | Main count offset above 80 |
| swal_code | input | 5 | Swallow count |
| test_sel | input | 3 | Status pin source select |
| ref_pulse | output | 1 | Reference comparison pulse |
| fb_pulse | output | 1 | Feedback comparison pulse |
| status | output | 1 | Lock flag or test signal |

## Verification
The reference and feedback pulses can land in the same clock cycle. The lock watcher must then score that cycle as one good period, without first opening a window for one pulse and then treating the other as a repeat. The bench provokes this by setting the reference ratio to 8 and the reference tick spacing to 320 cycles. It also starts the reference tick train so that the eighth tick falls on the 2560th VCO tick. Every comparison period then ends with both pulses in one cycle. The lock flag is judged by the behavioural model on every clock. Explicit checks confirm that the flag is still low after 15 periods and high after 16.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
    localparam int PRE_MOD   = 32;
    localparam int MAIN_W    = 4;
    localparam int SWAL_W    = 5;
    localparam int MAIN_BASE = 80;
    localparam int RATIO_LO  = 6;
    localparam int RATIO_HI  = 8;
    localparam int LOCK_WIN  = 8;
    localparam int LOCK_NEED = 16;

    typedef enum logic [1:0] {
        LK_IDLE     = 2'd0,
        LK_WAIT_FB  = 2'd1,
        LK_WAIT_REF = 2'd2
    } lk_state_e;
endpackage

// File: rtl/ratio_div.sv
module ratio_div #(
    parameter int LO = pll_div_pkg::RATIO_LO,
    parameter int HI = pll_div_pkg::RATIO_HI
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sel,
    output logic pulse_o,
    output logic tog_o
);
    localparam int CW = $clog2(HI + 1);

    typedef struct packed {
        logic          start;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          pulse;
        logic          tog;
    } rd_t;

    rd_t st_d, st_q;
    logic [CW-1:0] lim_use;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        lim_use    = st_q.start ? (sel ? CW'(HI) : CW'(LO)) : st_q.lim;
        cnt_nx     = st_q.start ? CW'(1) : st_q.cnt + 1'b1;
        if (tick) begin
            st_d.start = 1'b0;
            st_d.lim   = lim_use;
            st_d.cnt   = cnt_nx;
            if (cnt_nx == lim_use) begin
                st_d.start = 1'b1;
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                st_d.tog   = ~st_q.tog;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{start: 1'b1, default: '0};
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign tog_o   = st_q.tog;

    a_r10_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);
    a_r1_cnt_below_lim: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.start |-> (st_q.cnt < st_q.lim));
endmodule

// File: rtl/swallow_div.sv
module swallow_div #(
    parameter int MAIN_W    = pll_div_pkg::MAIN_W,
    parameter int SWAL_W    = pll_div_pkg::SWAL_W,
    parameter int MAIN_BASE = pll_div_pkg::MAIN_BASE,
    parameter int PRE_MOD   = pll_div_pkg::PRE_MOD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [MAIN_W-1:0] main_code,
    input  logic [SWAL_W-1:0] swal_code,
    output logic              pulse_o,
    output logic              tog_o
);
    localparam int PW = $clog2(PRE_MOD + 2);
    localparam int MW = $clog2(MAIN_BASE + (1 << MAIN_W));

    typedef struct packed {
        logic              start;
        logic [PW-1:0]     pc;
        logic [MW-1:0]     m_rem;
        logic [SWAL_W-1:0] s_rem;
        logic              pulse;
        logic              tog;
    } sd_t;

    sd_t st_d, st_q;
    logic [MW-1:0]     m_cur;
    logic [SWAL_W-1:0] s_cur;
    logic [PW-1:0]     pc_nx;
    logic [PW-1:0]     modulus;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        m_cur   = st_q.start ? MW'(MAIN_BASE) + MW'(main_code) : st_q.m_rem;
        s_cur   = st_q.start ? swal_code : st_q.s_rem;
        pc_nx   = st_q.start ? PW'(1) : st_q.pc + 1'b1;
        modulus = (s_cur != '0) ? PW'(PRE_MOD + 1) : PW'(PRE_MOD);
        if (tick) begin
            st_d.start = 1'b0;
            st_d.pc    = pc_nx;
            st_d.m_rem = m_cur;
            st_d.s_rem = s_cur;
            if (pc_nx == modulus) begin
                st_d.pc    = '0;
                st_d.s_rem = (s_cur != '0) ? s_cur - 1'b1 : s_cur;
                if (m_cur == MW'(1)) begin
                    st_d.start = 1'b1;
                    st_d.m_rem = '0;
                    st_d.s_rem = '0;
                    st_d.pulse = 1'b1;
                    st_d.tog   = ~st_q.tog;
                end else begin
                    st_d.m_rem = m_cur - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{start: 1'b1, default: '0};
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign tog_o   = st_q.tog;

    a_r2_swallow_le_main: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.start |-> (MW'(st_q.s_rem) <= st_q.m_rem));
    a_r10_fb_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);
endmodule

// File: rtl/lock_watch.sv
module lock_watch
    import pll_div_pkg::*;
#(
    parameter int WIN  = LOCK_WIN,
    parameter int NEED = LOCK_NEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic fb_i,
    input  logic vco_en,
    output logic lock_o
);
    localparam int WC = $clog2(WIN + 1);
    localparam int GC = $clog2(NEED + 1);

    typedef struct packed {
        lk_state_e     st;
        logic [WC-1:0] wcnt;
        logic [GC-1:0] good;
        logic          lock;
    } lw_t;

    lw_t lw_d, lw_q;
    logic good_ev, bad_ev;
    logic [GC-1:0] good_nx;

    always_comb begin
        lw_d    = lw_q;
        good_ev = 1'b0;
        bad_ev  = 1'b0;
        unique case (lw_q.st)
            LK_WAIT_FB, LK_WAIT_REF: begin
                if ((lw_q.st == LK_WAIT_FB) ? fb_i : ref_i) begin
                    good_ev = 1'b1;
                    lw_d.wcnt = '0;
                    lw_d.st = ((lw_q.st == LK_WAIT_FB) ? ref_i : fb_i) ? lw_q.st : LK_IDLE;
                end else if ((lw_q.st == LK_WAIT_FB) ? ref_i : fb_i) begin
                    bad_ev    = 1'b1;
                    lw_d.wcnt = '0;
                end else if (vco_en) begin
                    if (lw_q.wcnt == WC'(WIN)) begin
                        bad_ev    = 1'b1;
                        lw_d.st   = LK_IDLE;
                        lw_d.wcnt = '0;
                    end else begin
                        lw_d.wcnt = lw_q.wcnt + 1'b1;
                    end
                end
            end
            default: begin
                lw_d.wcnt = '0;
                if (ref_i && fb_i) good_ev = 1'b1;
                else if (ref_i)    lw_d.st = LK_WAIT_FB;
                else if (fb_i)     lw_d.st = LK_WAIT_REF;
            end
        endcase
        good_nx = (lw_q.good == GC'(NEED)) ? lw_q.good : lw_q.good + 1'b1;
        if (bad_ev) begin
            lw_d.good = '0;
            lw_d.lock = 1'b0;
        end else if (good_ev) begin
            lw_d.good = good_nx;
            lw_d.lock = (good_nx == GC'(NEED));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lw_q <= '{st: LK_IDLE, default: '0};
        else        lw_q <= lw_d;
    end

    assign lock_o = lw_q.lock;

    a_r7_rise_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lw_q.lock) |-> $past(ref_i || fb_i));
    a_r8_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lw_q.wcnt <= WC'(WIN));
    a_r7_lock_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        lw_q.lock |-> (lw_q.good == GC'(NEED)));
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
    import pll_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              vco_en,
    input  logic              ref_sel,
    input  logic [MAIN_W-1:0] main_code,
    input  logic [SWAL_W-1:0] swal_code,
    input  logic [2:0]        test_sel,
    output logic              ref_pulse,
    output logic              fb_pulse,
    output logic              status
);
    logic ref_tog, fb_tog, lock;

    ratio_div #(.LO(RATIO_LO), .HI(RATIO_HI)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(ref_en), .sel(ref_sel),
        .pulse_o(ref_pulse), .tog_o(ref_tog)
    );

    swallow_div #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MAIN_BASE(MAIN_BASE),
                  .PRE_MOD(PRE_MOD)) u_fb (
        .clk(clk), .rst_n(rst_n), .tick(vco_en), .main_code(main_code),
        .swal_code(swal_code), .pulse_o(fb_pulse), .tog_o(fb_tog)
    );

    lock_watch #(.WIN(LOCK_WIN), .NEED(LOCK_NEED)) u_lock (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_pulse), .fb_i(fb_pulse),
        .vco_en(vco_en), .lock_o(lock)
    );

    always_comb begin
        case (test_sel)
            3'b000, 3'b100: status = lock;
            3'b001, 3'b101: status = fb_tog;
            3'b010, 3'b110: status = ref_tog;
            3'b111:         status = ref_pulse;
            default:        status = 1'b0;
        endcase
    end

    a_r6_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 3'b011) |-> !status);
endmodule

// File: tb/pll_div_chain_tb.sv
module pll_div_chain_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_en = 1'b0, vco_en = 1'b0, ref_sel = 1'b0;
    logic [3:0] main_code = '0;
    logic [4:0] swal_code = '0;
    logic [2:0] test_sel = '0;
    logic ref_pulse, fb_pulse, status;

    always #10 clk = ~clk;

    pll_div_chain u_dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .vco_en(vco_en),
        .ref_sel(ref_sel), .main_code(main_code), .swal_code(swal_code),
        .test_sel(test_sel), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .status(status)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int rp = 320, rc = 1, vg = 1, vc = 0;
    bit done = 0;
    int fbt[$];
    int rft[$];
    logic prev_ref = 0, prev_fb = 0;

    // behavioural model state
    int m_rcnt, m_rlim, m_fcnt, m_fn, m_st, m_wc, m_good;
    bit m_rpulse, m_rtog, m_fpulse, m_ftog, m_lock;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rcnt = 0; m_rlim = 6; m_fcnt = 0; m_fn = 1; m_st = 0; m_wc = 0; m_good = 0;
        m_rpulse = 0; m_rtog = 0; m_fpulse = 0; m_ftog = 0; m_lock = 0;
    endtask

    task automatic model_step();
        bit r, f, good, bad;
        r = m_rpulse; f = m_fpulse; good = 0; bad = 0;
        if (!rst_n) begin model_reset(); return; end
        // lock watcher: 0 idle, 1 waiting for feedback, 2 waiting for reference
        if (m_st == 0) begin
            if (r && f) good = 1;
            else if (r) m_st = 1;
            else if (f) m_st = 2;
            m_wc = 0;
        end else begin
            bit want, same;
            want = (m_st == 1) ? f : r;
            same = (m_st == 1) ? r : f;
            if (want) begin good = 1; m_wc = 0; if (!same) m_st = 0; end
            else if (same) begin bad = 1; m_wc = 0; end
            else if (vco_en) begin
                if (m_wc == 8) begin bad = 1; m_st = 0; m_wc = 0; end
                else m_wc++;
            end
        end
        if (bad) begin m_good = 0; m_lock = 0; end
        else if (good) begin
            if (m_good < 16) m_good++;
            m_lock = (m_good == 16);
        end
        m_rpulse = 0;
        if (ref_en) begin
            if (m_rcnt == 0) m_rlim = ref_sel ? 8 : 6;
            m_rcnt++;
            if (m_rcnt == m_rlim) begin m_rpulse = 1; m_rtog = !m_rtog; m_rcnt = 0; end
        end
        m_fpulse = 0;
        if (vco_en) begin
            if (m_fcnt == 0) m_fn = 32 * (80 + int'(main_code)) + int'(swal_code);
            m_fcnt++;
            if (m_fcnt == m_fn) begin m_fpulse = 1; m_ftog = !m_ftog; m_fcnt = 0; end
        end
    endtask

    task automatic step();
        bit exp_st;
        @(negedge clk);
        cyc++;
        check(ref_pulse === m_rpulse, "R1 ref_pulse", int'(ref_pulse), int'(m_rpulse));
        check(fb_pulse === m_fpulse, "R2 fb_pulse", int'(fb_pulse), int'(m_fpulse));
        case (test_sel)
            3'b000, 3'b100: begin exp_st = m_lock;
                check(status === exp_st, "R4 lock on status", int'(status), int'(exp_st)); end
            3'b001, 3'b101: begin exp_st = m_ftog;
                check(status === exp_st, "R5 fb half", int'(status), int'(exp_st)); end
            3'b010, 3'b110: begin exp_st = m_rtog;
                check(status === exp_st, "R5 ref half", int'(status), int'(exp_st)); end
            3'b111: begin exp_st = m_rpulse;
                check(status === exp_st, "R6 raw ref", int'(status), int'(exp_st)); end
            default: check(status === 1'b0, "R6 quiet code", int'(status), 0);
        endcase
        if (ref_pulse) begin
            check(!prev_ref, "R10 ref single", int'(prev_ref), 0);
            rft.push_back(cyc);
        end
        if (fb_pulse) begin
            check(!prev_fb, "R10 fb single", int'(prev_fb), 0);
            fbt.push_back(cyc);
        end
        prev_ref = ref_pulse; prev_fb = fb_pulse;
        if (rst_n) begin
            ref_en = (rc == 0); rc = (rc + 1) % rp;
            vco_en = (vc == 0); vc = (vc + 1) % vg;
        end else begin
            ref_en = 0; vco_en = 0;
        end
        model_step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        int t_chg, idx;
        model_reset();
        ref_sel = 1; main_code = 0; swal_code = 0; test_sel = 3'b000;
        run(4);
        check(ref_pulse === 0 && fb_pulse === 0 && status === 0, "R9 reset outputs",
              int'(ref_pulse | fb_pulse | status), 0);
        rst_n = 1; rc = 1; vc = 0; rp = 320; vg = 1;
        // pulses coincide every 2560 cycles; 15 periods done but not 16
        run(15 * 2560 + 20);
        check(status === 1'b0, "R7 no lock after 15 periods", int'(status), 0);
        run(2560);
        check(status === 1'b1, "R7 lock after 16 periods", int'(status), 1);
        for (int c = 0; c < 8; c++) begin
            test_sel = 3'(c);
            run(2700);
        end
        test_sel = 3'b000;
        // mid-cycle swallow change: drift of 5 ticks per period
        run(1000);
        t_chg = cyc;
        swal_code = 5;
        run(9000);
        check(status === 1'b0, "R8 lock cleared by drift", int'(status), 0);
        idx = 0;
        while (idx < fbt.size() && fbt[idx] <= t_chg) idx++;
        if (idx >= 1 && idx + 1 < fbt.size()) begin
            check(fbt[idx] - fbt[idx-1] == 2560, "R3 old setting kept", fbt[idx] - fbt[idx-1], 2560);
            check(fbt[idx+1] - fbt[idx] == 2565, "R3 new setting applied", fbt[idx+1] - fbt[idx], 2565);
        end else check(0, "R3 feedback pulses missing", fbt.size(), idx + 2);
        // ratio 6, sparse VCO ticks, largest modulus
        ref_sel = 0; rp = 7; vg = 3; main_code = 4'hF; swal_code = 5'd31;
        test_sel = 3'b101;
        run(20000);
        check(rft.size() >= 2 && rft[$] - rft[$-1] == 42, "R1 ratio six period",
              rft[$] - rft[$-1], 42);
        check(fbt.size() >= 2 && fbt[$] - fbt[$-1] == 3 * 3071, "R2 largest modulus",
              fbt[$] - fbt[$-1], 3 * 3071);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule